// File: doc/BRIEF.md
# Post-Modify Address Generator

This block sits in front of a load/store pipe and turns one memory instruction's operands into two results: the address the access uses, and the value the base register takes afterwards. It covers six addressing modes: an absolute-set form, post-increment by a modifier register or by an immediate, a bit-reversed form for FFT-style buffers, and two circular-buffer forms whose step comes either from the immediate or from a field packed into the modifier register and scaled by the access size.

The decode stage presents the mode, the base and modifier register values, the bank of circular start registers with an index into it, the immediate and the access size, all qualified by a valid strobe. The results leave through one register stage a cycle later. A write-back enable tells the register file whether the base changes. A second enable, with its value, covers the extra destination that the absolute-set mode writes.

Top module: `pm_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_vld`, `ea`, `base_new`, `base_wb`, `aux_val` and `aux_we` are all zero.
- R2: Results appear one clock after `in_vld` is sampled high, with `out_vld` high for that one cycle. A cycle with `in_vld` low drives `out_vld` low and leaves every data output unchanged.
- R3: Mode code 0 (absolute set): `ea` and `aux_val` are the immediate zero-extended, `aux_we`=1, `base_wb`=0, and `base_new` equals `base`.
- R4: Mode code 1 (post-increment by register): `ea`=`base`, `base_new`=`base`+`modr` modulo 2^32, `base_wb`=1.
- R5: Mode code 2 (post-increment by immediate): `ea`=`base`, `base_new`=`base` plus the sign-extended immediate, `base_wb`=1.
- R6: Mode code 3 (bit-reversed): `ea` keeps `base[31:16]` and has `base[15:0]` in reversed bit order (bit 0 goes to bit 15), and `base_new`=`base`+`modr`, `base_wb`=1.
- R7: Mode code 4 (circular, immediate step): `ea`=`base`; `base_new` is the circular sum of `base` and the sign-extended immediate in the buffer whose length is `modr[16:0]` and whose start is the start register chosen by `mod_idx` (slice `mod_idx` of `cs_bank`, 32 bits each).
- R8: Mode code 5 (circular, register step): the step is the 11-bit signed value `{modr[31:28], modr[23:17]}` shifted left by `size` (0 byte, 1 half, 2 word, 3 doubleword); otherwise as R7.
- R9: For a circular mode with non-zero length L, start S, base in [S, S+L-1] and a step of magnitude at most L, `base_new` lies in [S, S+L-1]: a sum reaching S+L or more has L taken off, a sum below S has L added. With length zero the circular modes add the step plainly.
- R10: Mode codes 6 and 7 are reserved: `ea`=`base`, `base_new`=`base`, `base_wb`=0, `aux_we`=0.
- R11: `aux_we` is 1 only for mode code 0, and `aux_val` is zero whenever `aux_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands valid this cycle |
| mode | input | 3 | Addressing mode code |
| base | input | 32 | Base register value |
| modr | input | 32 | Modifier register value |
| mod_idx | input | 1 | Selects the circular start register |
| cs_bank | input | 64 | Circular start registers, index 0 in the low slice |
| imm | input | 16 | Immediate operand |
| size | input | 2 | log2 of the access size in bytes |
| out_vld | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| base_new | output | 32 | Updated base value |
| base_wb | output | 1 | Write `base_new` back to the base register |
| aux_val | output | 32 | Value for the secondary destination |
| aux_we | output | 1 | Write `aux_val` to the secondary destination |

## Verification
The bench builds the block with its defaults: two start registers, a 16-bit immediate and bit reversal over the low 16 bits. Two start registers let one vector show that the index really picks the buffer. The 16-bit immediate brings the sign-extension boundary at 0x7FFF/0x8000 within reach of a single directed vector. With the default widths, circular buffers of up to a few hundred bytes can be exercised with steps that cross both buffer ends in every access size.

// File: rtl/pmag_pkg.sv
package pmag_pkg;

    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 17;
    localparam int STEP_W   = 11;
    localparam int STEP_HI_MSB = 31;
    localparam int STEP_HI_LSB = 28;
    localparam int STEP_LO_MSB = 23;
    localparam int STEP_LO_LSB = 17;
    localparam int STEP_HI_W = STEP_HI_MSB - STEP_HI_LSB + 1;
    localparam int STEP_LO_W = STEP_LO_MSB - STEP_LO_LSB + 1;
    localparam int WIDE_W   = ADDR_W + 2;

    typedef enum logic [2:0] {
        AM_ABS_SET  = 3'd0,
        AM_POST_REG = 3'd1,
        AM_POST_IMM = 3'd2,
        AM_BREV     = 3'd3,
        AM_CIRC_IMM = 3'd4,
        AM_CIRC_REG = 3'd5,
        AM_RSVD6    = 3'd6,
        AM_RSVD7    = 3'd7
    } am_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] base_new;
        logic              base_wb;
        logic [ADDR_W-1:0] aux_val;
        logic              aux_we;
    } agu_res_t;

    function automatic logic [STEP_W-1:0] step_field(input logic [ADDR_W-1:0] m);
        return {m[STEP_HI_MSB:STEP_HI_LSB], m[STEP_LO_MSB:STEP_LO_LSB]};
    endfunction

    function automatic logic [LEN_W-1:0] buf_len(input logic [ADDR_W-1:0] m);
        return m[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/pmag_brev.sv
module pmag_brev #(
    parameter int AW     = 32,
    parameter int BREV_W = 16
) (
    input  logic [AW-1:0] din,
    output logic [AW-1:0] dout
);
    generate
        for (genvar i = 0; i < BREV_W; i++) begin : g_rev
            assign dout[i] = din[BREV_W-1-i];
        end
        if (AW > BREV_W) begin : g_pass
            assign dout[AW-1:BREV_W] = din[AW-1:BREV_W];
        end
    endgenerate
endmodule

// File: rtl/pmag_circ.sv
module pmag_circ
    import pmag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LEN_W
) (
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        start,
    input  logic [LW-1:0]        len,
    input  logic signed [AW+1:0] step,
    output logic [AW-1:0]        base_new
);
    localparam int XW = AW + 2;

    logic [AW-1:0]        off;
    logic signed [XW-1:0] sum;
    logic signed [XW-1:0] len_x;
    logic signed [XW-1:0] adj;

    always_comb begin
        off   = base - start;
        len_x = $signed({{(XW-LW){1'b0}}, len});
        sum   = $signed({2'b00, off}) + step;
        if (sum >= len_x) begin
            adj = sum - len_x;
        end else if (sum < 0) begin
            adj = sum + len_x;
        end else begin
            adj = sum;
        end
        if (len == '0) begin
            base_new = base + step[AW-1:0];
        end else begin
            base_new = start + adj[AW-1:0];
        end
    end

    // Range check of the wrap arithmetic for in-buffer operands
    logic signed [XW-1:0] step_mag;
    always_comb begin
        step_mag = (step < 0) ? -step : step;
        if (len != '0 && $signed({2'b00, off}) < len_x && step_mag <= len_x) begin
            assert_wrap_range_R9: assert (adj >= 0 && adj < len_x)
                else $error("circular result left its buffer");
        end
    end
endmodule

// File: rtl/pmag_core.sv
module pmag_core
    import pmag_pkg::*;
#(
    parameter int NUM_MOD = 2,
    parameter int IMM_W   = 16,
    parameter int BREV_W  = 16,
    localparam int IDX_W  = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
    input  logic [2:0]                mode,
    input  logic [ADDR_W-1:0]         base,
    input  logic [ADDR_W-1:0]         modr,
    input  logic [IDX_W-1:0]          mod_idx,
    input  logic [NUM_MOD*ADDR_W-1:0] cs_bank,
    input  logic [IMM_W-1:0]          imm,
    input  logic [1:0]                size,
    output agu_res_t                  res
);
    logic [ADDR_W-1:0] starts [NUM_MOD];
    generate
        for (genvar k = 0; k < NUM_MOD; k++) begin : g_cs
            assign starts[k] = cs_bank[k*ADDR_W +: ADDR_W];
        end
    endgenerate

    am_mode_e          md;
    logic [ADDR_W-1:0] imm_z;
    logic [ADDR_W-1:0] imm_s;
    logic [ADDR_W-1:0] start_sel;
    logic [ADDR_W-1:0] brev_ea;
    logic [ADDR_W-1:0] circ_nb;
    logic signed [WIDE_W-1:0] fld_x;
    logic signed [WIDE_W-1:0] step;

    assign md        = am_mode_e'(mode);
    assign imm_z     = {{(ADDR_W-IMM_W){1'b0}}, imm};
    assign imm_s     = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign start_sel = (int'(mod_idx) < NUM_MOD) ? starts[mod_idx] : '0;

    always_comb begin
        logic [STEP_W-1:0] f;
        f     = step_field(modr);
        fld_x = {{(WIDE_W-STEP_W){f[STEP_W-1]}}, f};
        if (md == AM_CIRC_REG) begin
            step = fld_x <<< size;
        end else begin
            step = {{(WIDE_W-IMM_W){imm[IMM_W-1]}}, imm};
        end
    end

    pmag_brev #(.AW(ADDR_W), .BREV_W(BREV_W)) u_brev (
        .din  (base),
        .dout (brev_ea)
    );

    pmag_circ #(.AW(ADDR_W), .LW(LEN_W)) u_circ (
        .base     (base),
        .start    (start_sel),
        .len      (buf_len(modr)),
        .step     (step),
        .base_new (circ_nb)
    );

    always_comb begin
        res = '{ea: base, base_new: base, base_wb: 1'b0, aux_val: '0, aux_we: 1'b0};
        unique case (md)
            AM_ABS_SET: begin
                res.ea      = imm_z;
                res.aux_val = imm_z;
                res.aux_we  = 1'b1;
            end
            AM_POST_REG: begin
                res.base_new = base + modr;
                res.base_wb  = 1'b1;
            end
            AM_POST_IMM: begin
                res.base_new = base + imm_s;
                res.base_wb  = 1'b1;
            end
            AM_BREV: begin
                res.ea       = brev_ea;
                res.base_new = base + modr;
                res.base_wb  = 1'b1;
            end
            AM_CIRC_IMM, AM_CIRC_REG: begin
                res.base_new = circ_nb;
                res.base_wb  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pm_addr_gen.sv
module pm_addr_gen
    import pmag_pkg::*;
#(
    parameter int NUM_MOD = 2,
    parameter int IMM_W   = 16,
    parameter int BREV_W  = 16,
    localparam int IDX_W  = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_vld,
    input  logic [2:0]                mode,
    input  logic [ADDR_W-1:0]         base,
    input  logic [ADDR_W-1:0]         modr,
    input  logic [IDX_W-1:0]          mod_idx,
    input  logic [NUM_MOD*ADDR_W-1:0] cs_bank,
    input  logic [IMM_W-1:0]          imm,
    input  logic [1:0]                size,
    output logic                      out_vld,
    output logic [ADDR_W-1:0]         ea,
    output logic [ADDR_W-1:0]         base_new,
    output logic                      base_wb,
    output logic [ADDR_W-1:0]         aux_val,
    output logic                      aux_we
);
    agu_res_t res_d;
    agu_res_t res_q;
    logic     vld_q;

    pmag_core #(.NUM_MOD(NUM_MOD), .IMM_W(IMM_W), .BREV_W(BREV_W)) u_core (
        .mode    (mode),
        .base    (base),
        .modr    (modr),
        .mod_idx (mod_idx),
        .cs_bank (cs_bank),
        .imm     (imm),
        .size    (size),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) begin
                res_q <= res_d;
            end
        end
    end

    assign out_vld  = vld_q;
    assign ea       = res_q.ea;
    assign base_new = res_q.base_new;
    assign base_wb  = res_q.base_wb;
    assign aux_val  = res_q.aux_val;
    assign aux_we   = res_q.aux_we;

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(ea) && $stable(base_new)));

    assert_abs_set_R3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode == 3'd0) |=> (aux_we && !base_wb && aux_val == ea));

    assert_post_ea_R4: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (mode == 3'd1 || mode == 3'd2 || mode == 3'd4 || mode == 3'd5))
        |=> (ea == $past(base) && base_wb));

    assert_brev_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode == 3'd3) |=> (ea[ADDR_W-1:BREV_W] == $past(base[ADDR_W-1:BREV_W])));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode[2:1] == 2'b11) |=> (!base_wb && !aux_we && base_new == $past(base)));

    assert_aux_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !aux_we |-> aux_val == '0);
endmodule

// File: tb/pm_addr_gen_tb.sv
module pm_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [2:0]  mode;
    logic [31:0] base;
    logic [31:0] modr;
    logic [0:0]  mod_idx;
    logic [63:0] cs_bank;
    logic [15:0] imm;
    logic [1:0]  size;
    logic        out_vld;
    logic [31:0] ea;
    logic [31:0] base_new;
    logic        base_wb;
    logic [31:0] aux_val;
    logic        aux_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10ns clk = ~clk;

    pm_addr_gen u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .mode(mode), .base(base),
        .modr(modr), .mod_idx(mod_idx), .cs_bank(cs_bank), .imm(imm),
        .size(size), .out_vld(out_vld), .ea(ea), .base_new(base_new),
        .base_wb(base_wb), .aux_val(aux_val), .aux_we(aux_we)
    );

    localparam logic [31:0] CS0 = 32'h0000_1000;
    localparam logic [31:0] CS1 = 32'h0000_2000;

    typedef struct packed {
        logic [2:0]  mode;
        logic [31:0] base;
        logic [31:0] modr;
        logic [15:0] imm;
        logic [1:0]  size;
        logic        idx;
        logic [31:0] ea;
        logic [31:0] nb;
        logic        wb;
        logic        aux_we;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        // R3 absolute set
        '{3'd0, 32'h0000_0055, 32'h0, 16'h8123, 2'd0, 1'b0, 32'h0000_8123, 32'h0000_0055, 1'b0, 1'b1, 4'd3},
        // R4 post-increment by register, negative modifier
        '{3'd1, 32'h0000_0100, 32'hFFFF_FFF0, 16'h0, 2'd0, 1'b0, 32'h0000_0100, 32'h0000_00F0, 1'b1, 1'b0, 4'd4},
        // R5 negative immediate
        '{3'd2, 32'h0000_0200, 32'h0, 16'hFFFC, 2'd0, 1'b0, 32'h0000_0200, 32'h0000_01FC, 1'b1, 1'b0, 4'd5},
        // R5 largest positive immediate
        '{3'd2, 32'h0000_0001, 32'h0, 16'h7FFF, 2'd0, 1'b0, 32'h0000_0001, 32'h0000_8000, 1'b1, 1'b0, 4'd5},
        // R6 bit reversal, upper half kept
        '{3'd3, 32'hABCD_0001, 32'h4, 16'h0, 2'd0, 1'b0, 32'hABCD_8000, 32'hABCD_0005, 1'b1, 1'b0, 4'd6},
        // R6 reversal of a mixed pattern
        '{3'd3, 32'h0000_1234, 32'h0, 16'h0, 2'd0, 1'b0, 32'h0000_2C48, 32'h0000_1234, 1'b1, 1'b0, 4'd6},
        // R9 wrap at the top end
        '{3'd4, 32'h0000_1030, 32'h40, 16'h0010, 2'd0, 1'b0, 32'h0000_1030, 32'h0000_1000, 1'b1, 1'b0, 4'd9},
        // R9 wrap at the bottom end
        '{3'd4, 32'h0000_1004, 32'h40, 16'hFFF8, 2'd0, 1'b0, 32'h0000_1004, 32'h0000_103C, 1'b1, 1'b0, 4'd9},
        // R7 second start register
        '{3'd4, 32'h0000_2010, 32'h40, 16'h0004, 2'd0, 1'b1, 32'h0000_2010, 32'h0000_2014, 1'b1, 1'b0, 4'd7},
        // R8 field +3 scaled by word size, wraps
        '{3'd5, 32'h0000_1038, 32'h0006_0040, 16'h0, 2'd2, 1'b0, 32'h0000_1038, 32'h0000_1004, 1'b1, 1'b0, 4'd8},
        // R8 field -1 scaled by doubleword size, wraps below
        '{3'd5, 32'h0000_1000, 32'hF0FE_0040, 16'h0, 2'd3, 1'b0, 32'h0000_1000, 32'h0000_1038, 1'b1, 1'b0, 4'd8},
        // R8 field +5 at byte size
        '{3'd5, 32'h0000_1000, 32'h000A_0040, 16'h0, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_1005, 1'b1, 1'b0, 4'd8},
        // R9 zero length adds plainly
        '{3'd4, 32'h0000_1000, 32'h0, 16'h0020, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_1020, 1'b1, 1'b0, 4'd9},
        // R10 reserved code
        '{3'd6, 32'h0000_0777, 32'h1234, 16'h5555, 2'd1, 1'b0, 32'h0000_0777, 32'h0000_0777, 1'b0, 1'b0, 4'd10}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one operation and sample its registered result a clock later
    task automatic issue(input logic [2:0] m, input logic [31:0] b, input logic [31:0] r,
                         input logic [15:0] im, input logic [1:0] sz, input logic ix);
        @(negedge clk);
        mode = m; base = b; modr = r; imm = im; size = sz; mod_idx = ix; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    function automatic logic [31:0] circ_ref(input logic [31:0] b, input logic [31:0] s,
                                             input int len, input int stp);
        longint o;
        if (len == 0) return b + 32'(stp);
        o = longint'(b - s) + longint'(stp);
        if (o >= len) o = o - len;
        else if (o < 0) o = o + len;
        return s + 32'(o);
    endfunction

    task automatic check_vec(input string req, input logic [31:0] e_ea, input logic [31:0] e_nb,
                             input logic e_wb, input logic e_aux, input logic [31:0] e_auxv);
        check(out_vld == 1'b1, req, "out_vld", {31'b0, out_vld}, 32'd1);
        check(ea == e_ea, req, "ea", ea, e_ea);
        check(base_new == e_nb, req, "base_new", base_new, e_nb);
        check(base_wb == e_wb && aux_we == e_aux, req, "enables",
              {30'b0, base_wb, aux_we}, {30'b0, e_wb, e_aux});
        check(aux_val == e_auxv, req, "aux_val", aux_val, e_auxv);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_vld = 1'b0; mode = '0; base = '0; modr = '0;
        imm = '0; size = '0; mod_idx = '0;
        cs_bank = {CS1, CS0};
        repeat (3) @(negedge clk);
        // R1 outputs cleared during reset
        check(!out_vld && ea == 0 && base_new == 0 && !base_wb && aux_val == 0 && !aux_we,
              "R1", "reset state", ea, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_vld && ea == 0 && base_new == 0, "R1", "after reset", base_new, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d", v.req);
            issue(v.mode, v.base, v.modr, v.imm, v.size, v.idx);
            check_vec(tag, v.ea, v.nb, v.wb, v.aux_we, v.aux_we ? v.ea : 32'h0);
        end

        // R2 idle cycle: valid drops, data holds
        issue(3'd2, 32'h0000_4000, 32'h0, 16'h0010, 2'd0, 1'b0);
        check_vec("R2", 32'h0000_4000, 32'h0000_4010, 1'b1, 1'b0, 32'h0);
        mode = 3'd0; base = 32'hDEAD_BEEF; imm = 16'hFFFF;
        @(negedge clk);
        check(!out_vld, "R2", "out_vld idle", {31'b0, out_vld}, 32'd0);
        check(ea == 32'h0000_4000 && base_new == 32'h0000_4010, "R2", "hold ea",
              ea, 32'h0000_4000);

        // R11 absolute set followed by a non-absolute mode clears aux
        issue(3'd0, 32'h0, 32'h0, 16'h00AA, 2'd0, 1'b0);
        check_vec("R11", 32'h0000_00AA, 32'h0, 1'b0, 1'b1, 32'h0000_00AA);
        issue(3'd7, 32'h0000_0123, 32'h0, 16'h00AA, 2'd0, 1'b0);
        check_vec("R11", 32'h0000_0123, 32'h0000_0123, 1'b0, 1'b0, 32'h0);

        // R7 R8 R9 randomized circular accesses inside the buffer
        for (int k = 0; k < 300; k++) begin
            int len, off, stp, fld;
            logic        ix;
            logic [31:0] s, b, r;
            logic [15:0] im;
            logic [1:0]  sz;
            logic [10:0] f11;
            ix  = 1'($urandom);
            s   = ix ? CS1 : CS0;
            len = 1 + int'($urandom % 256);
            off = int'($urandom % len);
            b   = s + 32'(off);
            sz  = 2'($urandom);
            if (k % 2 == 0) begin
                stp = int'($urandom % (2 * len + 1)) - len;
                im  = 16'(stp);
                r   = 32'(len);
                issue(3'd4, b, r, im, sz, ix);
                check_vec("R7", b, circ_ref(b, s, len, stp), 1'b1, 1'b0, 32'h0);
            end else begin
                fld = int'($urandom % (2 * (len >> sz) + 1)) - (len >> sz);
                f11 = 11'(fld);
                r   = {f11[10:7], 4'b0, f11[6:0], 17'(len)};
                stp = fld * (1 << sz);
                issue(3'd5, b, r, 16'h0, sz, ix);
                check_vec("R8", b, circ_ref(b, s, len, stp), 1'b1, 1'b0, 32'h0);
            end
            check(base_new >= s && base_new < s + 32'(len), "R9", "in buffer",
                  base_new, s);
        end

        // R4 R5 R6 randomized linear modes
        for (int k = 0; k < 60; k++) begin
            logic [31:0] b, r, rv;
            logic [15:0] im;
            b  = $urandom;
            r  = $urandom;
            im = 16'($urandom);
            issue(3'd1, b, r, im, 2'd0, 1'b0);
            check_vec("R4", b, b + r, 1'b1, 1'b0, 32'h0);
            issue(3'd2, b, r, im, 2'd0, 1'b0);
            check_vec("R5", b, b + {{16{im[15]}}, im}, 1'b1, 1'b0, 32'h0);
            rv = b;
            for (int j = 0; j < 16; j++) rv[j] = b[15 - j];
            issue(3'd3, b, r, im, 2'd0, 1'b0);
            check_vec("R6", rv, b + r, 1'b1, 1'b0, 32'h0);
        end

        // R1 reset mid-stream clears registered results
        issue(3'd2, 32'h0000_0900, 32'h0, 16'h0001, 2'd0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!out_vld && ea == 0 && base_new == 0 && !base_wb, "R1", "re-reset",
              base_new, 32'h0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule